// File: doc/BRIEF.md
# Framebuffer to Page-Column Byte Packer

The block walks a byte-per-pixel image held row-major in a synchronous RAM and turns it into the byte stream a monochrome page-organized panel controller expects. The panel is cut into horizontal bands eight pixels tall, here called pages. Each output byte describes one column of one page. Its eight bits are the eight vertically stacked pixels of that column, and each bit is set when the stored pixel byte is nonzero. The whole frame goes out as one transaction to a downstream I2C byte-stream master. A single data-control byte leads the transaction, and the page-column bytes follow in page order with columns ascending.

A one-cycle request on `kick_i` starts a frame. `width_i` and `height_i` are sampled when the frame starts. `blank_i` is sampled with the request, and when it is high the block sends an all-zero frame of the same length without touching the RAM. A request that arrives while a frame is in flight is held and served directly after the running frame ends. The controller is a six-state machine. IDLE waits for a request. HDR presents the control byte. FETCH issues the eight row reads of one page column. DRAIN takes in the last read datum. EMIT presents the packed byte. FINISH raises the done pulse. The transitions are:

- IDLE to HDR on a request.
- HDR to FETCH, or to EMIT in blank mode, when the control byte is accepted.
- FETCH to DRAIN after the eighth read.
- DRAIN to EMIT.
- EMIT to FETCH or EMIT for the next column when the byte is accepted, and EMIT to FINISH when the accepted byte was the last one.
- FINISH to HDR if a request is held or new, otherwise FINISH to IDLE.

Top module: `pgcol_packer`

## Requirements
- R1: Data bytes are emitted page by page (page 0 first), and within a page for columns 0 through width−1, each page-column byte exactly once.
- R2: In the byte for page p and column c, bit k (0..7) carries pixel row p·8+k of column c, so bit 0 is the top row of the page.
- R3: A pixel contributes a 1 when its stored byte is nonzero (any value 0x01..0xFF) and a 0 when it is 0x00.
- R4: Every RAM read uses address (p·8+k)·width + c, stays below width·height, and a normal frame reads each pixel exactly once.
- R5: A frame consists of the control byte 0x40 first, followed by exactly width·height/8 data bytes. The height must be a nonzero multiple of 8 and the width at least 1.
- R6: With `blank_i` high at the request, all width·height/8 data bytes are 0x00 and `ram_rd_en_o` stays low for the whole frame.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value. No byte is lost or repeated under any ready pattern.
- R8: A request made while a frame is active is latched together with its blank setting and starts its own frame right after the current frame's done pulse. Its width and height are sampled when it starts.
- R9: `done_o` is high for exactly one cycle, the cycle after the last data byte is accepted, and `out_valid_o` is low in that cycle.
- R10: During and right after reset, `out_valid_o`, `ram_rd_en_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | One-cycle frame request |
| blank_i | input | 1 | Blank-frame mode, sampled with the request |
| width_i | input | W_W | Frame width in pixels |
| height_i | input | H_W | Frame height in pixels, a multiple of 8 |
| ram_rd_en_o | output | 1 | RAM read strobe |
| ram_rd_addr_o | output | AW | RAM read address |
| ram_rd_data_i | input | 8 | RAM read data, one cycle after the strobe |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream ready |
| done_o | output | 1 | Frame-complete pulse |

## Verification
The packing is driven with dense random pixels, sparse images that are mostly zero, and a repeating 0x01/0x00/0x80 pattern. The random images catch bit-order and address mistakes. The sparse images show whether a lone set pixel reaches the right bit. The fixed pattern separates a true nonzero test from a test on a single bit. The frame sizes run from one column up to the full 32×32, including odd widths, so the walk across the page boundary and the column-base jump are exercised. Ready is held steady or randomized at several densities to expose dropped or duplicated bytes. A blank request queued behind a normal frame shows that held requests, blank mode and the sampling of the dimensions work together.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FETCH,
        ST_DRAIN,
        ST_EMIT,
        ST_FINISH
    } pcp_state_e;

    localparam logic [7:0] DATA_CTRL_BYTE = 8'h40;
    localparam int         ROWS_PER_PAGE  = 8;
endpackage

// File: rtl/pcp_ctrl.sv
module pcp_ctrl
    import pcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic blank_i,
    input  logic out_ready_i,
    input  logic k_last_i,
    input  logic frame_last_i,
    output logic start_o,
    output logic issue_o,
    output logic step_o,
    output logic hdr_o,
    output logic valid_o,
    output logic blank_o,
    output logic done_o,
    output logic busy_o
);
    pcp_state_e state_q, state_d;
    logic       pend_q, pend_blank_q, blank_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (kick_i) state_d = ST_HDR;
            ST_HDR:    if (out_ready_i) state_d = blank_q ? ST_EMIT : ST_FETCH;
            ST_FETCH:  if (k_last_i) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_EMIT;
            ST_EMIT:   if (out_ready_i) begin
                           if (frame_last_i) state_d = ST_FINISH;
                           else              state_d = blank_q ? ST_EMIT : ST_FETCH;
                       end
            ST_FINISH: state_d = (pend_q || kick_i) ? ST_HDR : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_o = 1'b0;
        issue_o = 1'b0;
        step_o  = 1'b0;
        hdr_o   = 1'b0;
        valid_o = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   start_o = kick_i;
            ST_HDR:    begin hdr_o = 1'b1; valid_o = 1'b1; end
            ST_FETCH:  issue_o = 1'b1;
            ST_DRAIN:  ;
            ST_EMIT:   begin valid_o = 1'b1; step_o = out_ready_i; end
            ST_FINISH: begin done_o = 1'b1; start_o = pend_q || kick_i; end
            default:   ;
        endcase
    end

    assign blank_o = blank_q;
    assign busy_o  = (state_q != ST_IDLE);

    // request latch and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_blank_q <= 1'b0;
            blank_q      <= 1'b0;
        end else if (start_o) begin
            blank_q <= pend_q ? pend_blank_q : blank_i;
            pend_q  <= pend_q && kick_i;
            if (pend_q && kick_i) pend_blank_q <= blank_i;
        end else if (kick_i && state_q != ST_IDLE) begin
            pend_q       <= 1'b1;
            pend_blank_q <= blank_i;
        end
    end
endmodule

// File: rtl/pcp_walker.sv
module pcp_walker #(
    parameter int MAX_W = 32,
    parameter int MAX_H = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         issue_i,
    input  logic                         step_i,
    input  logic [$clog2(MAX_W+1)-1:0]   width_i,
    input  logic [$clog2(MAX_H+1)-1:0]   height_i,
    output logic [$clog2(MAX_W*MAX_H)-1:0] rd_addr_o,
    output logic [2:0]                   k_o,
    output logic                         k_last_o,
    output logic                         frame_last_o,
    output logic [$clog2(MAX_W*MAX_H):0] frame_px_o
);
    localparam int W_W = $clog2(MAX_W+1);
    localparam int H_W = $clog2(MAX_H+1);
    localparam int AW  = $clog2(MAX_W*MAX_H);
    localparam int PXW = AW + 1;

    logic [W_W-1:0] w_q, col_q;
    logic [H_W-1:0] h_q, page_q, pages;
    logic [2:0]     k_q;
    logic [AW-1:0]  colbase_q, off_q;
    logic           col_last, page_last;

    assign pages        = h_q >> 3;
    assign col_last     = (col_q == w_q - W_W'(1));
    assign page_last    = (page_q == pages - H_W'(1));
    assign frame_last_o = col_last && page_last;
    assign k_last_o     = (k_q == 3'd7);
    assign k_o          = k_q;
    assign rd_addr_o    = colbase_q + off_q;
    assign frame_px_o   = PXW'(w_q) * PXW'(h_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q       <= '0;
            h_q       <= '0;
            col_q     <= '0;
            page_q    <= '0;
            k_q       <= '0;
            colbase_q <= '0;
            off_q     <= '0;
        end else if (start_i) begin
            w_q       <= width_i;
            h_q       <= height_i;
            col_q     <= '0;
            page_q    <= '0;
            k_q       <= '0;
            colbase_q <= '0;
            off_q     <= '0;
        end else if (issue_i) begin
            k_q   <= k_q + 3'd1;
            off_q <= off_q + AW'(w_q);
        end else if (step_i) begin
            k_q   <= '0;
            off_q <= '0;
            if (col_last) begin
                col_q     <= '0;
                page_q    <= page_q + H_W'(1);
                // skip the seven remaining rows of the page just finished
                colbase_q <= colbase_q + AW'(1) + AW'(w_q) * AW'(7);
            end else begin
                col_q     <= col_q + W_W'(1);
                colbase_q <= colbase_q + AW'(1);
            end
        end
    end
endmodule

// File: rtl/pcp_gather.sv
module pcp_gather (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_i,
    input  logic [2:0] k_i,
    input  logic [7:0] rd_data_i,
    output logic [7:0] byte_o
);
    logic       vld_q;
    logic [2:0] kd_q;
    logic [7:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            kd_q  <= '0;
            acc_q <= '0;
        end else begin
            vld_q <= issue_i;
            kd_q  <= k_i;
            if (vld_q) acc_q[kd_q] <= (rd_data_i != 8'h00);
        end
    end

    assign byte_o = acc_q;
endmodule

// File: rtl/pgcol_packer.sv
module pgcol_packer
    import pcp_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int MAX_H = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          kick_i,
    input  logic                          blank_i,
    input  logic [$clog2(MAX_W+1)-1:0]    width_i,
    input  logic [$clog2(MAX_H+1)-1:0]    height_i,
    output logic                          ram_rd_en_o,
    output logic [$clog2(MAX_W*MAX_H)-1:0] ram_rd_addr_o,
    input  logic [7:0]                    ram_rd_data_i,
    output logic                          out_valid_o,
    output logic [7:0]                    out_data_o,
    input  logic                          out_ready_i,
    output logic                          done_o
);
    localparam int AW = $clog2(MAX_W*MAX_H);

    logic          start_w, issue_w, step_w, hdr_w, blank_w, busy_w;
    logic          k_last_w, frame_last_w;
    logic [2:0]    k_w;
    logic [7:0]    packed_w;
    logic [AW:0]   frame_px_w;

    pcp_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick_i       (kick_i),
        .blank_i      (blank_i),
        .out_ready_i  (out_ready_i),
        .k_last_i     (k_last_w),
        .frame_last_i (frame_last_w),
        .start_o      (start_w),
        .issue_o      (issue_w),
        .step_o       (step_w),
        .hdr_o        (hdr_w),
        .valid_o      (out_valid_o),
        .blank_o      (blank_w),
        .done_o       (done_o),
        .busy_o       (busy_w)
    );

    pcp_walker #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .issue_i      (issue_w),
        .step_i       (step_w),
        .width_i      (width_i),
        .height_i     (height_i),
        .rd_addr_o    (ram_rd_addr_o),
        .k_o          (k_w),
        .k_last_o     (k_last_w),
        .frame_last_o (frame_last_w),
        .frame_px_o   (frame_px_w)
    );

    pcp_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_w),
        .k_i       (k_w),
        .rd_data_i (ram_rd_data_i),
        .byte_o    (packed_w)
    );

    assign ram_rd_en_o = issue_w;
    assign out_data_o  = hdr_w   ? DATA_CTRL_BYTE :
                         blank_w ? 8'h00 : packed_w;
endmodule

// File: rtl/pgcol_packer_chk.sv
module pgcol_packer_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          ram_rd_en,
    input logic [AW-1:0] ram_rd_addr,
    input logic          done,
    input logic          blank_mode,
    input logic          busy,
    input logic [AW:0]   frame_px
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_noread_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && blank_mode |-> !ram_rd_en);

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> ({1'b0, ram_rd_addr} < frame_px));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !ram_rd_en);

    assert_read_vs_emit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ram_rd_en);
endmodule

bind pgcol_packer pgcol_packer_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid_o),
    .out_ready   (out_ready_i),
    .out_data    (out_data_o),
    .ram_rd_en   (ram_rd_en_o),
    .ram_rd_addr (ram_rd_addr_o),
    .done        (done_o),
    .blank_mode  (blank_w),
    .busy        (busy_w),
    .frame_px    (frame_px_w)
);

// File: tb/test_pgcol_packer.sv
module test_pgcol_packer;
    localparam int MAX_W = 32;
    localparam int MAX_H = 32;
    localparam int W_W   = $clog2(MAX_W+1);
    localparam int H_W   = $clog2(MAX_H+1);
    localparam int AW    = $clog2(MAX_W*MAX_H);
    localparam int NPIX  = MAX_W*MAX_H;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           kick, blank;
    logic [W_W-1:0] width;
    logic [H_W-1:0] height;
    logic           ram_rd_en;
    logic [AW-1:0]  ram_rd_addr;
    logic [7:0]     ram_rd_data;
    logic           out_valid;
    logic [7:0]     out_data;
    logic           out_ready;
    logic           done;

    logic [7:0] mem [NPIX];
    logic [7:0] cap [1024];
    int cap_n, done_cnt, rd_cnt, addr_bad, cur_px, ready_pct;
    int done_at [8];
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pgcol_packer #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_pgcol_packer (
        .clk           (clk),
        .rst_n         (rst_n),
        .kick_i        (kick),
        .blank_i       (blank),
        .width_i       (width),
        .height_i      (height),
        .ram_rd_en_o   (ram_rd_en),
        .ram_rd_addr_o (ram_rd_addr),
        .ram_rd_data_i (ram_rd_data),
        .out_valid_o   (out_valid),
        .out_data_o    (out_data),
        .out_ready_i   (out_ready),
        .done_o        (done)
    );

    always @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];

    always @(posedge clk) begin
        #1;
        out_ready = (($urandom % 100) < ready_pct);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (cap_n < 1024) cap[cap_n] = out_data;
                cap_n++;
            end
            if (done) begin
                if (done_cnt < 8) done_at[done_cnt] = cap_n;
                done_cnt++;
            end
            if (ram_rd_en) begin
                rd_cnt++;
                if (int'(ram_rd_addr) >= cur_px) addr_bad++;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int p, int c, int w);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = (mem[(p*8+k)*w + c] != 8'h00);
        return b;
    endfunction

    task automatic fill(int pat);
        for (int i = 0; i < NPIX; i++) begin
            case (pat)
                0: mem[i] = (($urandom % 4) == 0) ? 8'h00 : 8'(($urandom % 255) + 1);
                1: mem[i] = (($urandom % 10) == 0) ? 8'(($urandom % 255) + 1) : 8'h00;
                default: mem[i] = (i % 3 == 0) ? 8'h01 : ((i % 3 == 1) ? 8'h00 : 8'h80);
            endcase
        end
    endtask

    task automatic verify(int base, int w, int h, bit blk);
        check("R5 control byte", int'(cap[base]), 64);
        for (int p = 0; p < h/8; p++)
            for (int c = 0; c < w; c++) begin
                int idx = base + 1 + p*w + c;
                logic [7:0] e = blk ? 8'h00 : exp_byte(p, c, w);
                check($sformatf("R1 R2 R3 R6 byte p%0d c%0d", p, c), int'(cap[idx]), int'(e));
            end
    endtask

    task automatic wait_done(int n);
        int t = 0;
        while (done_cnt < n && t < 30000) begin
            @(negedge clk);
            t++;
        end
        check("R9 done seen (timeout)", int'(done_cnt >= n), 1);
    endtask

    task automatic clear_counts();
        cap_n = 0; done_cnt = 0; rd_cnt = 0; addr_bad = 0;
    endtask

    task automatic run_frame(int w, int h, bit blk, int pat, int rp);
        fill(pat);
        cur_px = w*h;
        ready_pct = rp;
        @(negedge clk);
        clear_counts();
        width = W_W'(w); height = H_W'(h); blank = blk; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        wait_done(1);
        verify(0, w, h, blk);
        check("R9 done after last byte", done_at[0], 1 + w*h/8);
        repeat (20) @(negedge clk);
        check("R5 R7 byte count", cap_n, 1 + w*h/8);
        check("R9 single done", done_cnt, 1);
        check("R4 address range", addr_bad, 0);
        if (blk) check("R6 no reads in blank mode", rd_cnt, 0);
        else     check("R4 one read per pixel", rd_cnt, w*h);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; kick = 1'b0; blank = 1'b0; width = '0; height = '0;
        out_ready = 1'b0; ready_pct = 100; cur_px = 0;
        cap_n = 0; done_cnt = 0; rd_cnt = 0; addr_bad = 0;
        repeat (3) @(negedge clk);
        check("R10 valid in reset", int'(out_valid), 0);
        check("R10 read in reset", int'(ram_rd_en), 0);
        check("R10 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid after reset", int'(out_valid), 0);
        check("R10 done after reset", int'(done), 0);

        run_frame(8, 8, 1'b0, 2, 100);     // threshold pattern, R3
        run_frame(32, 32, 1'b0, 0, 40);    // dense random, backpressure R7
        run_frame(1, 8, 1'b0, 0, 100);     // single column
        run_frame(24, 16, 1'b0, 1, 60);    // sparse
        run_frame(32, 32, 1'b1, 0, 50);    // blank frame R6
        run_frame(5, 24, 1'b0, 2, 30);     // odd width, heavy stall

        // R8: blank request queued behind a running frame
        fill(0);
        cur_px = 16*16;
        ready_pct = 70;
        @(negedge clk);
        clear_counts();
        width = W_W'(16); height = H_W'(16); blank = 1'b0; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        repeat (5) @(negedge clk);
        width = W_W'(8); height = H_W'(8); blank = 1'b1; kick = 1'b1;
        @(negedge clk);
        kick = 1'b0; blank = 1'b0;
        wait_done(2);
        verify(0, 16, 16, 1'b0);
        verify(done_at[0], 8, 8, 1'b1);
        check("R8 first frame length", done_at[0], 1 + 32);
        check("R8 queued frame length", done_at[1] - done_at[0], 1 + 8);
        check("R8 queued blank frame made no reads", rd_cnt, 256);

        for (int i = 0; i < 4; i++) begin
            int w = 1 + int'($urandom % MAX_W);
            int h = 8 * (1 + int'($urandom % (MAX_H/8)));
            run_frame(w, h, (($urandom % 4) == 0), int'($urandom % 3), 20 + int'($urandom % 81));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule